// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Pre-Shift

This block multiplies two 16-bit operands and either returns one half of the 32-bit product or folds the product into a 32-bit accumulator. Each operation chooses signed or unsigned operands. A multiply-add or multiply-subtract can shift the product left by up to two bits before it reaches the accumulator. Such a shift lines up fractional fixed-point products without any extra instructions.

There are two stages. The first stage forms the product and its shifted form. The second stage adds the shifted product to the accumulator or subtracts it, or it delivers the selected word of a plain multiply. The second stage reads the accumulator register that it also writes, so a new operation can start on every cycle with no stall. Back-to-back accumulations build one sum. A clear input sets the accumulator to zero. A load-first flag starts a new sum from the current product.

Top module: `mac_preshift`

## Requirements
- R1: While rst_n is low, and directly after it is released, `acc_value` is 0 and `mul_valid` is 0.
- R2: An operation with `in_op` = 2'b00 (multiply) issued at clock edge k raises `mul_valid` after edge k+1, for one cycle. `mul_result` then holds product bits [15:0] when `in_hi` = 0, or bits [31:16] when `in_hi` = 1.
- R3: When `in_signed` = 1 both operands are read as two's complement. When it is 0 both are read as unsigned. The 32-bit product follows from this choice.
- R4: An operation with `in_op` = 2'b01 (multiply-add) issued at edge k adds the shifted product to the accumulator. The new sum appears on `acc_value` after edge k+1.
- R5: An operation with `in_op` = 2'b10 (multiply-subtract) subtracts the shifted product from the accumulator, with the same timing as R4.
- R6: `in_shift` gives a left shift of 0, 1 or 2 bits, which is applied to the product before accumulation. The code 2'b11 shifts by 2.
- R7: The accumulator wraps modulo 2^32, with no saturation. Bits shifted out above bit 31 are lost.
- R8: A multiply-add or multiply-subtract issued with `in_load` = 1 uses 0 in place of the old accumulator value. The result is the shifted product or its negative.
- R9: `acc_clr` high at an edge with no accumulation in the second stage leaves `acc_value` at 0. If an accumulation is in the second stage at that same edge, the result is 0 plus or minus its shifted term.
- R10: One operation can be issued on every cycle. Consecutive accumulations each see the sum left by the one before.
- R11: A multiply (2'b00) and the reserved code 2'b11 leave the accumulator unchanged. Neither 2'b01, 2'b10 nor 2'b11 raises `mul_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 reserved |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_signed | input | 1 | 1 = two's complement operands |
| in_shift | input | 2 | Pre-accumulation left shift (0..2, 3 acts as 2) |
| in_hi | input | 1 | Multiply returns the high word |
| in_load | input | 1 | Start a new sum from this product |
| acc_clr | input | 1 | Zero the accumulator |
| acc_value | output | 32 | Accumulator contents |
| mul_valid | output | 1 | Multiply result present |
| mul_result | output | 16 | Selected word of the product |

## Verification
A clear on `acc_clr` can land on the same edge at which an earlier accumulation reaches the second stage. The block must then act as if the sum started from zero. This overlap is forced by directed sequences that issue a multiply-add and raise the clear one cycle later. The random phase also drives the clear at a low rate together with continuous issue. The bench's cycle model applies the zero base before adding the term and compares `acc_value` on every cycle, so either order of the clear and the add, if wrongly implemented, shows as a mismatch.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DW = 16;
  localparam int PW = 2 * DW;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_MAC = 2'b01,
    OP_MAS = 2'b10,
    OP_NOP = 2'b11
  } mac_op_e;

  // full product of two operands, signedness chosen per call
  function automatic logic [PW-1:0] full_product(input logic [DW-1:0] a,
                                                 input logic [DW-1:0] b,
                                                 input logic sgn);
    logic signed [DW:0]     ax;
    logic signed [DW:0]     bx;
    logic signed [2*DW+1:0] p;
    ax = {sgn & a[DW-1], a};
    bx = {sgn & b[DW-1], b};
    p  = ax * bx;
    return p[PW-1:0];
  endfunction

  // pre-accumulation shift, code 3 capped to 2
  function automatic logic [PW-1:0] shift_term(input logic [PW-1:0] p,
                                               input logic [1:0] sh);
    logic [1:0] eff;
    eff = (sh == 2'd3) ? 2'd2 : sh;
    return p << eff;
  endfunction
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_pkg::*;
#(
  parameter int W = DW,
  localparam int P = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  mac_op_e      in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_signed,
  input  logic [1:0]   in_shift,
  input  logic         in_hi,
  input  logic         in_load,
  output logic         s1_valid,
  output mac_op_e      s1_op,
  output logic [P-1:0] s1_prod,
  output logic [P-1:0] s1_term,
  output logic         s1_hi,
  output logic         s1_load
);
  logic         issue;
  logic [P-1:0] prod_c;
  logic [P-1:0] term_c;

  assign issue  = in_valid && (in_op != OP_NOP);
  assign prod_c = full_product(in_a, in_b, in_signed);
  assign term_c = shift_term(prod_c, in_shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_NOP;
      s1_prod  <= '0;
      s1_term  <= '0;
      s1_hi    <= 1'b0;
      s1_load  <= 1'b0;
    end else begin
      s1_valid <= issue;
      if (issue) begin
        s1_op   <= in_op;
        s1_prod <= prod_c;
        s1_term <= term_c;
        s1_hi   <= in_hi;
        s1_load <= in_load;
      end
    end
  end

  AST_NOP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_NOP) |=> !s1_valid); // R11
  AST_SHIFT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != OP_NOP && in_shift == 2'd3) |=> (s1_term == (s1_prod << 2))); // R6
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int W = DW,
  localparam int P = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s1_valid,
  input  mac_op_e      s1_op,
  input  logic [P-1:0] s1_prod,
  input  logic [P-1:0] s1_term,
  input  logic         s1_hi,
  input  logic         s1_load,
  input  logic         acc_clr,
  output logic [P-1:0] acc,
  output logic         mul_valid,
  output logic [W-1:0] mul_result
);
  logic         do_accum;
  logic         do_sub;
  logic         do_mul;
  logic         base_zero;
  logic [P-1:0] base;
  logic [P-1:0] acc_next;

  assign do_mul    = s1_valid && (s1_op == OP_MUL);
  assign do_accum  = s1_valid && (s1_op == OP_MAC || s1_op == OP_MAS);
  assign do_sub    = (s1_op == OP_MAS);
  assign base_zero = acc_clr || s1_load;
  assign base      = base_zero ? '0 : acc;

  always_comb begin
    acc_next = acc;
    if (do_accum)     acc_next = do_sub ? (base - s1_term) : (base + s1_term);
    else if (acc_clr) acc_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      mul_valid  <= 1'b0;
      mul_result <= '0;
    end else begin
      acc       <= acc_next;
      mul_valid <= do_mul;
      if (do_mul) mul_result <= s1_hi ? s1_prod[P-1:W] : s1_prod[W-1:0];
    end
  end

  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !do_accum) |=> (acc == '0)); // R9
  AST_MUL_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_accum && !acc_clr) |=> $stable(acc)); // R11
  AST_MULV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mul_valid |-> $past(s1_valid && s1_op == OP_MUL)); // R2
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (do_accum && s1_load && s1_op == OP_MAC) |=> (acc == $past(s1_term))); // R8
endmodule

// File: rtl/mac_preshift.sv
module mac_preshift
  import mac_pkg::*;
#(
  parameter int W = DW,
  localparam int P = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_signed,
  input  logic [1:0]   in_shift,
  input  logic         in_hi,
  input  logic         in_load,
  input  logic         acc_clr,
  output logic [P-1:0] acc_value,
  output logic         mul_valid,
  output logic [W-1:0] mul_result
);
  logic         s1_valid;
  mac_op_e      s1_op;
  logic [P-1:0] s1_prod;
  logic [P-1:0] s1_term;
  logic         s1_hi;
  logic         s1_load;

  mac_mul_stage #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(mac_op_e'(in_op)),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed), .in_shift(in_shift),
    .in_hi(in_hi), .in_load(in_load),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_prod(s1_prod), .s1_term(s1_term),
    .s1_hi(s1_hi), .s1_load(s1_load)
  );

  mac_acc_stage #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_op(s1_op),
    .s1_prod(s1_prod), .s1_term(s1_term), .s1_hi(s1_hi), .s1_load(s1_load),
    .acc_clr(acc_clr), .acc(acc_value), .mul_valid(mul_valid),
    .mul_result(mul_result)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_value == '0 && !mul_valid)); // R1
endmodule

// File: tb/mac_preshift_bench.sv
module mac_preshift_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b11;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_shift = '0;
  logic        in_hi = 1'b0;
  logic        in_load = 1'b0;
  logic        acc_clr = 1'b0;
  logic [31:0] acc_value;
  logic        mul_valid;
  logic [15:0] mul_result;

  int checks = 0;
  int fails = 0;

  // model state
  logic [31:0] m_acc = '0;
  logic        m_mv = 1'b0;
  logic [15:0] m_mr = '0;
  logic        p_v = 1'b0;
  logic [1:0]  p_op = '0;
  logic [31:0] p_prod = '0;
  logic [31:0] p_term = '0;
  logic        p_hi = 1'b0;
  logic        p_ld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_preshift u_mac_preshift (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed), .in_shift(in_shift),
    .in_hi(in_hi), .in_load(in_load), .acc_clr(acc_clr),
    .acc_value(acc_value), .mul_valid(mul_valid), .mul_result(mul_result)
  );

  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b,
                                           input logic sgn);
    longint x, y, r;
    x = sgn ? longint'($signed(a)) : longint'(a);
    y = sgn ? longint'($signed(b)) : longint'(b);
    r = x * y;
    return r[31:0];
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] p, input logic [1:0] s);
    case (s)
      2'd0:    return p;
      2'd1:    return p * 32'd2;
      default: return p * 32'd4;
    endcase
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic step(input logic v, input logic [1:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic sgn, input logic [1:0] sh,
                      input logic hi, input logic ld, input logic clr, input string tag);
    logic [31:0] base;
    in_valid = v; in_op = op; in_a = a; in_b = b; in_signed = sgn;
    in_shift = sh; in_hi = hi; in_load = ld; acc_clr = clr;
    @(posedge clk);
    m_mv = p_v && p_op == 2'b00;
    if (m_mv) m_mr = p_hi ? p_prod[31:16] : p_prod[15:0];
    base = (clr || p_ld) ? 32'd0 : m_acc;
    if (p_v && p_op == 2'b01)      m_acc = base + p_term;
    else if (p_v && p_op == 2'b10) m_acc = base - p_term;
    else if (clr)                  m_acc = 32'd0;
    p_v = v && op != 2'b11;
    if (p_v) begin
      p_op = op; p_prod = ref_prod(a, b, sgn); p_term = ref_shift(p_prod, sh);
      p_hi = hi; p_ld = ld;
    end
    @(negedge clk);
    check32(tag, "acc_value", acc_value, m_acc);
    check32(tag, "mul_valid", {31'd0, mul_valid}, {31'd0, m_mv});
    if (m_mv) check32(tag, "mul_result", {16'd0, mul_result}, {16'd0, m_mr});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'b11, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BADF00D));
    repeat (3) @(negedge clk);
    check32("R1", "acc_value in reset", acc_value, 32'd0);
    check32("R1", "mul_valid in reset", {31'd0, mul_valid}, 32'd0);
    rst_n = 1'b1;
    idle("R1");

    // R2 words and R3 signedness
    step(1, 2'b00, 16'h1234, 16'h5678, 0, 0, 0, 0, 0, "R2");
    step(1, 2'b00, 16'h1234, 16'h5678, 0, 0, 1, 0, 0, "R2");
    step(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 0, 1, 0, 0, "R3");
    step(1, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, "R3");
    step(1, 2'b00, 16'h8000, 16'h7FFF, 1, 0, 1, 0, 0, "R3");
    idle("R2"); idle("R2");

    // R4, R5, R6 shifts
    step(1, 2'b01, 16'd100, 16'd3, 0, 0, 0, 1, 0, "R8");
    step(1, 2'b01, 16'd7, 16'd5, 0, 1, 0, 0, 0, "R4");
    step(1, 2'b10, 16'd2, 16'd9, 0, 2, 0, 0, 0, "R5");
    step(1, 2'b01, 16'd11, 16'd1, 0, 3, 0, 0, 0, "R6");
    step(1, 2'b10, 16'hFFFE, 16'd3, 1, 1, 0, 0, 0, "R6");
    idle("R4"); idle("R5");

    // R7 wrap
    step(1, 2'b01, 16'hFFFF, 16'hFFFF, 0, 2, 0, 1, 0, "R7");
    step(1, 2'b01, 16'hFFFF, 16'hFFFF, 0, 2, 0, 0, 0, "R7");
    step(1, 2'b10, 16'h8000, 16'h8000, 1, 2, 0, 0, 0, "R7");
    idle("R7"); idle("R7");

    // R8 load-first with subtract
    step(1, 2'b10, 16'd10, 16'd10, 0, 0, 0, 1, 0, "R8");
    idle("R8"); idle("R8");

    // R9 clear alone, then clear colliding with accumulate in stage 2
    idle("R9");
    step(0, 2'b11, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(1, 2'b01, 16'd50, 16'd50, 0, 0, 0, 0, 0, "R9");
    step(1, 2'b01, 16'd3, 16'd4, 0, 1, 0, 0, 1, "R9");
    step(0, 2'b11, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle("R9"); idle("R9");

    // R11 multiply and reserved code leave the sum alone
    step(1, 2'b01, 16'd9, 16'd9, 0, 0, 0, 1, 0, "R11");
    step(1, 2'b00, 16'd77, 16'd77, 0, 0, 0, 0, 0, "R11");
    step(1, 2'b11, 16'd77, 16'd77, 0, 0, 0, 0, 0, "R11");
    idle("R11"); idle("R11");

    // R10 back-to-back random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], 16'($urandom), 16'($urandom), r[4], r[6:5], r[7],
           (r[11:8] == 4'd0), (r[15:12] == 4'd0), "R10");
    end
    idle("R10"); idle("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule